// File: doc/BRIEF.md
# Multi-Channel Programmable Down-Counter Timer

This block is a bank of independent down-counting timers behind a simple single-cycle register bus. Each channel holds a load value, a reload value used at expiry in periodic mode, and a control word. The control word selects enable, a divide-by-1 or divide-by-16 tick rate, a 32-bit or 16-bit counting width, and one of three behaviours: free-running wrap, periodic reload, or one-shot stop. A write to the load register is not applied immediately. The counter picks it up at the next tick of that channel.

Each expiry sets a per-channel latched status bit. A mask register selects which channels can drive the single combined interrupt output. Software clears status bits through a write-one-to-clear register. The bank is used as a system tick source or as a one-shot event timer. A typical setup uses one channel as a free-running time base and another as a one-shot event generator.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every readable register, every counter value, bus_rdata and irq are zero.
- R2: Byte address map. Channel c occupies c*16 + {0: load, 4: current value (read-only), 8: control, 12: reload}. The global block follows at NCH*16 + {0: mask, 4: raw status, 8: masked status, 12: clear (reads zero)}. Control bits are 0 one-shot, 1 32-bit width, 2 divide-by-16, 3 periodic, 4 enable. Control bits above bit 4 read zero. The mask holds one bit per channel, with bit i for channel i. Any address not in the map reads zero. Read data appears on bus_rdata one cycle after the read request.
- R3: A load write takes effect at the first channel tick after the write. Until then, the value register keeps its old contents, and this holds even while the channel is disabled.
- R4: An enabled channel with divide-by-1 ticks every clock. With divide-by-16, the first tick comes 16 clocks after enable and further ticks follow every 16 clocks. Each tick decrements the counter by one.
- R5: With enable clear, the counter holds its value.
- R6: In free-running mode the counter wraps from 0 to all ones of the selected width. A load of 0 therefore runs the full range. With the width bit clear, only the low 16 bits count, and loaded values are truncated to 16 bits.
- R7: In one-shot mode, after a load of N (N >= 2) is applied, the counter reaches 0 N ticks later. That step sets the channel's raw status bit, and the counter then stays at 0.
- R8: In periodic mode, a tick at value 1 reloads the counter from the reload register instead of stepping to 0. Such a tick also sets the raw status bit.
- R9: The masked status equals raw AND mask. irq is the registered OR of the masked status. It rises two clocks after the expiring tick's edge.
- R10: Writing the clear register clears the raw bits written as 1 and leaves the other raw bits unchanged.
- R11: Channels are independent. Activity on one channel does not change another channel's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest behaviour to reach from the ports is the deferred load: the value becomes visible only at the next channel tick, not on the bus write. This is hardest in divide-by-16 mode, where the tick phase is hidden state. The bench reaches a known phase by writing the load while the channel is disabled and then enabling it. This fixes the prescaler phase to the enable write, so every later read and irq transition can be placed on an exact cycle. Sweeps over channels and one-shot lengths then check the expiry cycle through the irq pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_ONE   = 0;
  localparam int CTL_WIDE  = 1;
  localparam int CTL_DIV16 = 2;
  localparam int CTL_PER   = 3;
  localparam int CTL_EN    = 4;
  localparam int CTL_W     = 5;

  typedef struct packed {
    logic en;
    logic per;
    logic div16;
    logic wide;
    logic one;
  } ctl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic slow,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || !en) pre <= '0;
    else if (pre == LAST) pre <= '0;
    else pre <= pre + 1'b1;
  end

  assign tick = en && (!slow || pre == LAST);

  // R4
  slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && slow && en) |=> (!tick || !slow));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld_wr,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] bg_val,
  input  logic         one,
  input  logic         per,
  input  logic         wide,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam int HW = W / 2;

  logic         pend;
  logic [W-1:0] msk;

  assign msk    = wide ? {W{1'b1}} : {{(W-HW){1'b0}}, {HW{1'b1}}};
  assign expire = tick && !pend && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (ld_wr) pend <= 1'b1;
      else if (tick) pend <= 1'b0;
      if (tick) begin
        if (pend) cnt <= ld_val & msk;
        else if (one && cnt == '0) cnt <= cnt;
        else if (per && !one && cnt == W'(1)) cnt <= bg_val & msk;
        else cnt <= (cnt - 1'b1) & msk;
      end
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && one && !pend && cnt == '0) |=> (cnt == '0));
  // R6
  narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wide) |=> (cnt[W-1:HW] == '0));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] mask,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] raw,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      irq <= 1'b0;
    end else begin
      raw <= (raw & ~(clr_we ? clr_bits : '0)) | ev;
      irq <= |(raw & mask);
    end
  end

  // R9
  raw_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw & ~$past(raw) & ~$past(ev)) == '0));
  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((raw & $past(clr_bits) & ~$past(ev)) == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 32,
  parameter int AW  = 8,
  parameter int DIV = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);
  localparam int IW = AW - 4;

  logic [IW-1:0]  idx;
  logic [1:0]     sel;
  logic           unused_lsb;
  logic [W-1:0]   load_v [NCH];
  logic [W-1:0]   bg_v   [NCH];
  logic [W-1:0]   cnt_v  [NCH];
  ctl_t           ctl_v  [NCH];
  logic [NCH-1:0] ev;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] raw;
  logic           gw;
  logic [W-1:0]   rd_mux;

  assign idx        = bus_addr[AW-1:4];
  assign sel        = bus_addr[3:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign gw         = bus_en && bus_wr && (idx == IW'(NCH));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic         hit;
    logic [W-1:0] ld_r;
    logic [W-1:0] bg_r;
    ctl_t         ctl_r;
    logic         tick;

    assign hit = bus_en && bus_wr && (idx == IW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        ld_r  <= '0;
        bg_r  <= '0;
        ctl_r <= '0;
      end else if (hit) begin
        if (sel == 2'd0) ld_r  <= bus_wdata;
        if (sel == 2'd2) ctl_r <= ctl_t'(bus_wdata[CTL_W-1:0]);
        if (sel == 2'd3) bg_r  <= bus_wdata;
      end
    end

    tmr_prescale #(.DIV(DIV)) u_pre (
      .clk (clk),
      .rst (rst),
      .en  (ctl_r.en),
      .slow(ctl_r.div16),
      .tick(tick)
    );

    tmr_count #(.W(W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .ld_wr (hit && sel == 2'd0),
      .ld_val(ld_r),
      .bg_val(bg_r),
      .one   (ctl_r.one),
      .per   (ctl_r.per),
      .wide  (ctl_r.wide),
      .cnt   (cnt_v[c]),
      .expire(ev[c])
    );

    assign load_v[c] = ld_r;
    assign bg_v[c]   = bg_r;
    assign ctl_v[c]  = ctl_r;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (gw && sel == 2'd0) mask_q <= bus_wdata[NCH-1:0];
  end

  tmr_irq #(.N(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .mask    (mask_q),
    .clr_we  (gw && sel == 2'd3),
    .clr_bits(bus_wdata[NCH-1:0]),
    .raw     (raw),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (idx == IW'(c)) begin
        case (sel)
          2'd0:    rd_mux = load_v[c];
          2'd1:    rd_mux = cnt_v[c];
          2'd2:    rd_mux = {{(W-CTL_W){1'b0}}, ctl_v[c]};
          default: rd_mux = bg_v[c];
        endcase
      end
    end
    if (idx == IW'(NCH)) begin
      case (sel)
        2'd0:    rd_mux = W'(mask_q);
        2'd1:    rd_mux = W'(raw);
        2'd2:    rd_mux = W'(raw & mask_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_en && !bus_wr) bus_rdata <= rd_mux;
  end

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int NCH = 4;
  localparam int G   = NCH * 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int t0 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_bank u_tmr_bank (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_en = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a);
    @(negedge clk);
    bus_en = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic at_t(input int t);
    while (cyc - t0 < t) @(negedge clk);
  endtask

  function automatic int ca(input int ch, input int r);
    return ch * 16 + r * 4;
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] e;
    do_reset();

    // R1: reset state over the whole address space
    chk("R1 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 256; a += 4) rd_chk(a, 32'd0, "R1 reset read");

    // R2: readback, control field width, unused and clear reads
    for (int ch = 0; ch < NCH; ch++) begin
      wr(ca(ch, 0), 32'hA5A50000 + ch);
      wr(ca(ch, 3), 32'h0F0F0000 + ch);
      wr(ca(ch, 2), 32'hFFFFFFEF);
    end
    wr(G, 32'hFF);
    for (int ch = 0; ch < NCH; ch++) begin
      rd_chk(ca(ch, 0), 32'hA5A50000 + ch, "R2 load");
      rd_chk(ca(ch, 3), 32'h0F0F0000 + ch, "R2 reload");
      rd_chk(ca(ch, 2), 32'h0000000F, "R2 ctrl");
      rd_chk(ca(ch, 1), 32'd0, "R3 value untouched while disabled");
    end
    rd_chk(G, 32'hF, "R2 mask");
    rd_chk(G + 12, 32'd0, "R2 clear reads zero");
    for (int a = G + 16; a < 256; a += 4) rd_chk(a, 32'd0, "R2 unused");

    // R3 R4 R11: deferred load then divide-by-1 countdown, per channel
    for (int ch = 0; ch < NCH; ch++) begin
      do_reset();
      wr(ca(ch, 2), 32'h12);
      wr(ca(ch, 0), 100 + ch);
      t0 = cyc;
      for (int j = 1; j <= 8; j++) begin
        at_t(j);
        rd_chk(ca(ch, 1), 32'(100 + ch - j + 1), "R3/R4 countdown");
      end
      for (int o = 0; o < NCH; o++)
        if (o != ch) rd_chk(ca(o, 1), 32'd0, "R11 other channel");
    end

    // R5: disable holds; load while disabled applies after re-enable (R3)
    do_reset();
    wr(ca(2, 0), 1000);
    wr(ca(2, 2), 32'h12);
    t0 = cyc;
    at_t(20);
    wr(ca(2, 2), 32'h02);
    repeat (30) @(negedge clk);
    rd_chk(ca(2, 1), 32'd980, "R5 hold");
    wr(ca(2, 0), 5);
    repeat (10) @(negedge clk);
    rd_chk(ca(2, 1), 32'd980, "R3 load deferred while disabled");
    wr(ca(2, 2), 32'h12);
    t0 = cyc;
    at_t(1);
    rd_chk(ca(2, 1), 32'd5, "R3 load applied on first tick");

    // R4: divide-by-16 tick phase from the enable write
    do_reset();
    wr(ca(1, 0), 50);
    wr(ca(1, 2), 32'h16);
    t0 = cyc;
    at_t(15); rd_chk(ca(1, 1), 32'd0,  "R4 div16 before first tick");
    at_t(16); rd_chk(ca(1, 1), 32'd50, "R4 div16 first tick");
    at_t(31); rd_chk(ca(1, 1), 32'd50, "R4 div16 hold");
    at_t(32); rd_chk(ca(1, 1), 32'd49, "R4 div16 second tick");
    at_t(47); rd_chk(ca(1, 1), 32'd49, "R4 div16 hold2");
    at_t(48); rd_chk(ca(1, 1), 32'd48, "R4 div16 third tick");

    // R6: free-running wrap, 32-bit and 16-bit, full range from 0
    do_reset();
    wr(ca(0, 2), 32'h12);
    wr(ca(0, 0), 2);
    t0 = cyc;
    for (int j = 1; j <= 5; j++) begin
      at_t(j);
      rd_chk(ca(0, 1), (j <= 3) ? 32'(3 - j) : 32'hFFFFFFFF - 32'(j - 4), "R6 wrap32");
    end
    do_reset();
    wr(ca(3, 2), 32'h10);
    wr(ca(3, 0), 32'hABCD0001);
    t0 = cyc;
    for (int j = 1; j <= 4; j++) begin
      at_t(j);
      rd_chk(ca(3, 1), (j <= 2) ? 32'(2 - j) : 32'h0000FFFF - 32'(j - 3), "R6 wrap16");
    end
    do_reset();
    wr(ca(1, 2), 32'h12);
    wr(ca(1, 0), 0);
    t0 = cyc;
    at_t(1); rd_chk(ca(1, 1), 32'd0, "R6 load zero");
    at_t(2); rd_chk(ca(1, 1), 32'hFFFFFFFF, "R6 full range");

    // R7 R9 R10: one-shot sweep over channels and lengths
    for (int ch = 0; ch < NCH; ch++) begin
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? 2 : (k == 1) ? 3 : 7;
        do_reset();
        wr(G, 32'(1 << ch));
        wr(ca(ch, 2), 32'h13);
        wr(ca(ch, 0), 32'(n));
        t0 = cyc;
        for (int t = 0; t <= n + 5; t++) begin
          at_t(t);
          chk("R7/R9 irq timing", {31'b0, irq}, (t >= n + 2) ? 32'd1 : 32'd0);
        end
        repeat (40) @(negedge clk);
        rd_chk(ca(ch, 1), 32'd0, "R7 stays at zero");
        rd_chk(G + 4, 32'(1 << ch), "R7 raw");
        rd_chk(G + 8, 32'(1 << ch), "R9 masked");
        wr(G + 12, 32'(1 << ch));
        rd_chk(G + 4, 32'd0, "R10 cleared");
        chk("R9 irq low after clear", {31'b0, irq}, 32'd0);
      end
    end

    // R8: periodic reload from reload register
    do_reset();
    wr(ca(2, 3), 4);
    wr(G, 32'h4);
    wr(ca(2, 2), 32'h1A);
    wr(ca(2, 0), 3);
    t0 = cyc;
    for (int t = 1; t <= 12; t++) begin
      at_t(t);
      chk("R8 irq", {31'b0, irq}, (t >= 5) ? 32'd1 : 32'd0);
      e = (t <= 3) ? 32'(4 - t) : 32'(4 - ((t - 4) % 4));
      rd_chk(ca(2, 1), e, "R8 periodic value");
    end
    rd_chk(G + 4, 32'h4, "R8 raw");

    // R9: mask gating
    do_reset();
    wr(ca(1, 2), 32'h13);
    wr(ca(1, 0), 2);
    repeat (10) @(negedge clk);
    chk("R9 masked off irq", {31'b0, irq}, 32'd0);
    rd_chk(G + 4, 32'h2, "R9 raw while masked");
    rd_chk(G + 8, 32'h0, "R9 masked zero");
    wr(G, 32'h1);
    @(negedge clk);
    chk("R9 wrong mask bit", {31'b0, irq}, 32'd0);
    wr(G, 32'h2);
    @(negedge clk);
    chk("R9 mask bit 1 drives irq", {31'b0, irq}, 32'd1);
    rd_chk(G + 8, 32'h2, "R9 masked one");

    // R10: selective clear
    do_reset();
    wr(G, 32'hF);
    wr(ca(0, 2), 32'h13);
    wr(ca(2, 2), 32'h13);
    wr(ca(0, 0), 2);
    wr(ca(2, 0), 2);
    repeat (10) @(negedge clk);
    rd_chk(G + 4, 32'h5, "R10 two raw bits");
    wr(G + 12, 32'h1);
    rd_chk(G + 4, 32'h4, "R10 clear bit 0 only");
    wr(G + 12, 32'h0);
    rd_chk(G + 4, 32'h4, "R10 zero write no effect");
    chk("R10 irq still high", {31'b0, irq}, 32'd1);
    wr(G + 12, 32'h4);
    @(negedge clk);
    rd_chk(G + 4, 32'h0, "R10 all cleared");
    chk("R10 irq low", {31'b0, irq}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule